// File: doc/BRIEF.md
# Soft-Repair Fuse Chain Loader

This controller sits between one repair analyser and several embedded memories that each hold their repair code in a serial fuse-data shift chain. When the test engine signals that a memory group has finished its test, the controller selects one memory by its ID and emits a counted burst of fuse-clock strobes on that memory's line only. On each strobe one repair-code bit from the analyser is passed to the memory's fuse-data input. The burst length is the selected memory's chain length, looked up from a parameter table.

A separate merge trigger runs an incremental repair. The burst first shifts the stored code out of the memory's fuse-data output towards the analyser. It then spends one idle strobe and shifts a merged code back in, so the burst is one pulse longer than twice the chain length. The merged code is formed by the analyser from the old code and the new fail encoding. Clock gating is modelled as one enable strobe per memory, which a glitch-free enable gate next to each memory turns into its fuse clock.

Top module: `fuse_soft_loader`

## Requirements
- R1: After reset all fuse-clock enables, `load_o`, `unload_o`, `busy_o`, `done_o` and `err_o` are 0.
- R2: A `start_i` accepted while idle with a valid ID gives exactly L(ID) strobes on consecutive cycles, the first one cycle after the trigger edge. The default lengths are 8, 12, 20 and 32 for IDs 0, 1, 2 and 3.
- R3: Only `fuse_clk_en_o[ID]` is ever high during a burst. The other lines stay 0 for the whole burst.
- R4: During every load strobe `load_o` is 1 and `fuse_data_o` equals `code_bit_i`. The first bit loaded therefore ends at the fuse-data output end of the chain.
- R5: A merge burst has 2·L(ID)+1 strobes. Strobes 0 to L−1 are unload strobes: `unload_o`=1 and `old_bit_o` equals the selected memory's fuse-data output. Strobe L is a gap with neither flag set. The last L strobes are load strobes.
- R6: `done_o` is high for exactly one cycle, the cycle after the last strobe. `busy_o` is high from the first strobe through the `done_o` cycle.
- R7: A trigger, with any ID, that arrives while `busy_o` is high is ignored. The running burst keeps its line and its length, and no extra burst follows.
- R8: A trigger with an ID ≥ NUM_MEM gives no strobe and no `done_o`. It gives a one-cycle `err_o` in the cycle after the trigger edge.
- R9: If `start_i` and `merge_start_i` are high together, the merge burst runs.
- R10: `fuse_data_o` and `old_bit_o` are 0 whenever their strobe type is not active, whatever `code_bit_i` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Load trigger from the test engine |
| merge_start_i | input | 1 | Incremental-repair trigger |
| mem_id_i | input | ID_W | Memory selected by the trigger |
| code_bit_i | input | 1 | Serial repair-code bit from the analyser |
| mem_fdo_i | input | NUM_MEM | Fuse-data outputs of the memories |
| fuse_clk_en_o | output | NUM_MEM | Per-memory fuse-clock enable strobes |
| fuse_data_o | output | 1 | Serial fuse data to the selected memory |
| old_bit_o | output | 1 | Old code bit returned to the analyser |
| unload_o | output | 1 | Current strobe reads the old code |
| load_o | output | 1 | Current strobe consumes `code_bit_i` |
| busy_o | output | 1 | Burst or done cycle in progress |
| done_o | output | 1 | One-cycle end-of-burst flag |
| err_o | output | 1 | One-cycle invalid-ID flag |

## Verification
Every valid ID is swept in both modes, with each of the codes all-ones, alternating bits and a spread pseudo-random value, over chains preloaded with a different content. This separates errors in the length lookup, in line selection and in bit order. In merge runs the bench acts as the analyser: it rebuilds the old code from the unloaded bits and checks that the chain ends holding old OR new, which exposes misplaced gap or phase boundaries. Invalid IDs, a second trigger injected mid-burst with another ID, and simultaneous triggers test the rejection, ignore and priority rules. `code_bit_i` toggles on every cycle so that leakage outside load strobes shows up.

// File: rtl/fsl_pkg.sv
`timescale 1ns/1ps
// fsl_pkg: shared types of the soft-repair fuse chain loader.
// Assumes nothing beyond a single clock domain.
package fsl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } fsl_state_t;
endpackage

// File: rtl/fsl_len_table.sv
`timescale 1ns/1ps
// fsl_len_table: maps a memory ID to its fuse chain length.
// Assumes every table entry is at least 1. An ID at or above NUM_MEM
// returns valid_o = 0 and length 0.
module fsl_len_table #(
    parameter int unsigned NUM_MEM = 4,
    parameter int unsigned ID_W    = 3,
    parameter int unsigned LEN_W   = 8,
    parameter logic [NUM_MEM*LEN_W-1:0] LEN_VEC = '0
) (
    input  logic [ID_W-1:0]  id_i,
    output logic [LEN_W-1:0] len_o,
    output logic             valid_o
);
    logic [NUM_MEM-1:0] hit;

    // one comparator per table slot
    for (genvar i = 0; i < NUM_MEM; i++) begin : g_hit
        assign hit[i] = (id_i == ID_W'(i));
    end

    // select the matching length (at most one hit)
    always_comb begin
        len_o   = '0;
        valid_o = 1'b0;
        for (int i = 0; i < NUM_MEM; i++) begin
            if (hit[i]) begin
                len_o   = LEN_VEC[i*LEN_W +: LEN_W];
                valid_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/fsl_burst_ctr.sv
`timescale 1ns/1ps
// fsl_burst_ctr: counts fuse strobes of one burst and reports its phase.
// On start_i it captures the length and mode. In normal mode the burst is
// len strobes, all load. In merge mode it is 2*len+1 strobes: len unload,
// one gap, len load. Assumes run_i is high only between start and last.
module fsl_burst_ctr #(
    parameter int unsigned LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             merge_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             run_i,
    output logic             last_o,
    output logic             unload_o,
    output logic             gap_o,
    output logic             load_o
);
    localparam int unsigned CNT_W = LEN_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] total_q;
    logic [LEN_W-1:0] len_q;
    logic             merge_q;
    logic [CNT_W-1:0] len_ext;

    // capture burst geometry at start, advance one per strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            total_q <= '0;
            len_q   <= '0;
            merge_q <= 1'b0;
        end else if (start_i) begin
            cnt_q   <= '0;
            len_q   <= len_i;
            merge_q <= merge_i;
            total_q <= merge_i ? {len_i, 1'b1} : {1'b0, len_i};
        end else if (run_i) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign len_ext  = {1'b0, len_q};
    assign last_o   = run_i && (cnt_q == total_q - CNT_W'(1));
    assign unload_o = run_i && merge_q && (cnt_q < len_ext);
    assign gap_o    = run_i && merge_q && (cnt_q == len_ext);
    assign load_o   = run_i && !unload_o && !gap_o;
endmodule

// File: rtl/fsl_fclk_gate.sv
`timescale 1ns/1ps
// fsl_fclk_gate: steers the burst strobe onto one memory's fuse-clock
// enable and returns that memory's fuse-data output. The enables drive
// glitch-free enable clock gates at the memories; this block only forms
// the enables. Assumes sel_i is stable while run_i is high.
module fsl_fclk_gate #(
    parameter int unsigned NUM_MEM = 4,
    parameter int unsigned ID_W    = 3
) (
    input  logic               run_i,
    input  logic [ID_W-1:0]    sel_i,
    input  logic [NUM_MEM-1:0] fdo_i,
    output logic [NUM_MEM-1:0] en_o,
    output logic               fdo_o
);
    logic [NUM_MEM-1:0] hit;

    // per-memory decode and enable gate
    for (genvar i = 0; i < NUM_MEM; i++) begin : g_line
        assign hit[i]  = (sel_i == ID_W'(i));
        assign en_o[i] = run_i && hit[i];
    end

    assign fdo_o = |(hit & fdo_i);
endmodule

// File: rtl/fuse_soft_loader.sv
`timescale 1ns/1ps
// fuse_soft_loader: top of the soft-repair fuse chain loader. It accepts
// a load or merge trigger while idle, checks the memory ID, then runs one
// strobe burst on the selected memory's fuse-clock enable. The serial
// data passes through in load strobes and the old code is returned in
// unload strobes. Triggers are ignored while busy. Assumes mem_id_i is
// valid together with the trigger, and merge wins over load.
module fuse_soft_loader #(
    parameter int unsigned NUM_MEM = 4,
    parameter int unsigned ID_W    = 3,
    parameter int unsigned LEN_W   = 8,
    parameter logic [NUM_MEM*LEN_W-1:0] LEN_VEC = {8'd32, 8'd20, 8'd12, 8'd8}
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               merge_start_i,
    input  logic [ID_W-1:0]    mem_id_i,
    input  logic               code_bit_i,
    input  logic [NUM_MEM-1:0] mem_fdo_i,
    output logic [NUM_MEM-1:0] fuse_clk_en_o,
    output logic               fuse_data_o,
    output logic               old_bit_o,
    output logic               unload_o,
    output logic               load_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               err_o
);
    import fsl_pkg::*;

    fsl_state_t       state_q;
    logic [ID_W-1:0]  sel_q;
    logic             err_q;
    logic             trig;
    logic             accept;
    logic             go;
    logic             run;
    logic [LEN_W-1:0] id_len;
    logic             id_ok;
    logic             last;
    logic             unload;
    logic             gap;
    logic             load;
    logic             fdo_sel;

    assign trig   = start_i || merge_start_i;
    assign accept = (state_q == ST_IDLE) && trig;
    assign go     = accept && id_ok;
    assign run    = (state_q == ST_RUN);

    fsl_len_table #(
        .NUM_MEM (NUM_MEM),
        .ID_W    (ID_W),
        .LEN_W   (LEN_W),
        .LEN_VEC (LEN_VEC)
    ) u_len (
        .id_i    (mem_id_i),
        .len_o   (id_len),
        .valid_o (id_ok)
    );

    fsl_burst_ctr #(
        .LEN_W (LEN_W)
    ) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (go),
        .merge_i  (merge_start_i),
        .len_i    (id_len),
        .run_i    (run),
        .last_o   (last),
        .unload_o (unload),
        .gap_o    (gap),
        .load_o   (load)
    );

    fsl_fclk_gate #(
        .NUM_MEM (NUM_MEM),
        .ID_W    (ID_W)
    ) u_gate (
        .run_i (run),
        .sel_i (sel_q),
        .fdo_i (mem_fdo_i),
        .en_o  (fuse_clk_en_o),
        .fdo_o (fdo_sel)
    );

    // burst sequencing: idle -> run -> done cycle -> idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: if (go)   state_q <= ST_RUN;
                ST_RUN:  if (last) state_q <= ST_FIN;
                ST_FIN:            state_q <= ST_IDLE;
                default:           state_q <= ST_IDLE;
            endcase
        end
    end

    // hold the selected memory for the whole burst
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (go) begin
            sel_q <= mem_id_i;
        end
    end

    // one-cycle flag for a rejected ID
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= accept && !id_ok;
        end
    end

    // gap is neither load nor unload, so both data paths are quiet there
    assign fuse_data_o = load && code_bit_i;
    assign old_bit_o   = unload && fdo_sel;
    assign unload_o    = unload;
    assign load_o      = load && !gap;
    assign busy_o      = (state_q != ST_IDLE);
    assign done_o      = (state_q == ST_FIN);
    assign err_o       = err_q;
endmodule

// File: rtl/fsl_checker.sv
`timescale 1ns/1ps
// fsl_checker: protocol properties of fuse_soft_loader, bound to the top.
module fsl_checker #(
    parameter int unsigned NUM_MEM = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_MEM-1:0] fuse_clk_en_o,
    input logic               fuse_data_o,
    input logic               old_bit_o,
    input logic               unload_o,
    input logic               load_o,
    input logic               busy_o,
    input logic               done_o,
    input logic               err_o
);
    a_r3_one_line: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fuse_clk_en_o));

    a_r3_line_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (|fuse_clk_en_o && $past(|fuse_clk_en_o)) |-> fuse_clk_en_o == $past(fuse_clk_en_o));

    a_r4_load_strobed: assert property (@(posedge clk) disable iff (!rst_n)
        (load_o || unload_o) |-> (|fuse_clk_en_o));

    a_r5_phase_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_o && unload_o));

    a_r6_done_after_burst: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (fuse_clk_en_o == '0) && $past(|fuse_clk_en_o));

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r6_busy_during: assert property (@(posedge clk) disable iff (!rst_n)
        (|fuse_clk_en_o || done_o) |-> busy_o);

    a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (fuse_clk_en_o == '0) && !busy_o);

    a_r10_data_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_o |-> !fuse_data_o) and (!unload_o |-> !old_bit_o));
endmodule

bind fuse_soft_loader fsl_checker #(.NUM_MEM(NUM_MEM)) u_fsl_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .fuse_clk_en_o (fuse_clk_en_o),
    .fuse_data_o   (fuse_data_o),
    .old_bit_o     (old_bit_o),
    .unload_o      (unload_o),
    .load_o        (load_o),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .err_o         (err_o)
);

// File: tb/fuse_soft_loader_bench.sv
`timescale 1ns/1ps
module fuse_soft_loader_bench;
    localparam int NM = 4;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          merge_start_i = 1'b0;
    logic [IW-1:0] mem_id_i = '0;
    logic          code_bit_i = 1'b0;
    logic [NM-1:0] mem_fdo_i;
    logic [NM-1:0] fuse_clk_en_o;
    logic          fuse_data_o, old_bit_o, unload_o, load_o, busy_o, done_o, err_o;

    int checks = 0;
    int errors = 0;

    logic [31:0] chain [NM];
    logic        pre_en = 1'b0;
    int          pre_id = 0;
    logic [31:0] pre_val = '0;

    always #2 clk = ~clk;

    fuse_soft_loader u_fuse_soft_loader (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .merge_start_i(merge_start_i),
        .mem_id_i(mem_id_i), .code_bit_i(code_bit_i), .mem_fdo_i(mem_fdo_i),
        .fuse_clk_en_o(fuse_clk_en_o), .fuse_data_o(fuse_data_o), .old_bit_o(old_bit_o),
        .unload_o(unload_o), .load_o(load_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
    );

    function automatic int explen(input int id);
        case (id)
            0: return 8;
            1: return 12;
            2: return 20;
            default: return 32;
        endcase
    endfunction

    // memory fuse chain models
    always_ff @(posedge clk) begin
        for (int i = 0; i < NM; i++) begin
            if (pre_en && pre_id == i) chain[i] <= pre_val;
            else if (fuse_clk_en_o[i]) chain[i] <= {chain[i][30:0], fuse_data_o};
        end
    end

    always_comb begin
        for (int i = 0; i < NM; i++) mem_fdo_i[i] = chain[i][explen(i)-1];
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // one trigger and the observation of its whole burst
    task automatic run_burst(input int id, input bit do_start, input bit do_merge,
                             input logic [31:0] prior, input logic [31:0] ncode,
                             input bit inject, input string tag);
        bit valid = (id < NM);
        int L = valid ? explen(id) : 0;
        int T = !valid ? 0 : (do_merge ? 2*L+1 : L);
        logic [31:0] mask = 32'((64'h1 << L) - 1);
        logic [31:0] old_rec = '0;
        int pulses = 0, first = -1, last = -1, others = 0;
        int done_cnt = 0, done_cyc = -1, busy_cnt = 0, err_cnt = 0, err_cyc = -1;
        int phase_bad = 0, data_bad = 0, quiet_bad = 0;
        if (valid) begin
            @(negedge clk); pre_en = 1'b1; pre_id = id; pre_val = prior & mask;
            @(negedge clk); pre_en = 1'b0;
        end
        @(negedge clk);
        start_i = do_start; merge_start_i = do_merge; mem_id_i = IW'(id);
        @(negedge clk);
        start_i = 1'b0; merge_start_i = 1'b0;
        for (int cyc = 1; cyc <= 80; cyc++) begin
            bit p_on = valid && fuse_clk_en_o[id];
            if (valid && (fuse_clk_en_o & ~(NM'(1) << id)) != '0) others++;
            if (!valid && fuse_clk_en_o != '0) others++;
            if (busy_o) busy_cnt++;
            if (done_o) begin done_cnt++; done_cyc = cyc; end
            if (err_o) begin err_cnt++; err_cyc = cyc; end
            code_bit_i = cyc[0];
            if (p_on) begin
                int p = pulses;
                if (first < 0) first = cyc;
                last = cyc;
                if (do_merge && p < L) begin
                    if (!unload_o || load_o) phase_bad++;
                    old_rec[L-1-p] = old_bit_o;
                end else if (do_merge && p == L) begin
                    if (unload_o || load_o) phase_bad++;
                end else begin
                    int q = do_merge ? p - L - 1 : p;
                    if (!load_o || unload_o) phase_bad++;
                    code_bit_i = do_merge ? (old_rec[L-1-q] | ncode[L-1-q]) : ncode[L-1-q];
                end
                pulses++;
            end
            #1;
            if (load_o && fuse_data_o != code_bit_i) data_bad++;
            if (!load_o && fuse_data_o) quiet_bad++;
            if (!unload_o && old_bit_o) quiet_bad++;
            if (inject && cyc == 4) begin start_i = 1'b1; mem_id_i = IW'((id + 1) % NM); end
            if (inject && cyc == 5) start_i = 1'b0;
            @(negedge clk);
        end
        chk(pulses == T, {tag, " R2 R5 strobe count"}, pulses, T);
        if (valid) begin
            chk(first == 1 && last == T, {tag, " R2 consecutive from cycle 1"}, last, T);
            chk(done_cnt == 1 && done_cyc == T + 1, {tag, " R6 done cycle"}, done_cyc, T + 1);
            chk(busy_cnt == T + 1, {tag, " R6 busy span"}, busy_cnt, T + 1);
            chk(phase_bad == 0, {tag, " R5 phase flags"}, phase_bad, 0);
            chk(data_bad == 0, {tag, " R4 data pass-through"}, data_bad, 0);
            chk((chain[id] & mask) == (do_merge ? ((prior | ncode) & mask) : (ncode & mask)),
                {tag, " R4 R5 final chain"}, chain[id] & mask,
                do_merge ? ((prior | ncode) & mask) : (ncode & mask));
            if (do_merge) chk(old_rec == (prior & mask), {tag, " R5 old code returned"}, old_rec, prior & mask);
            chk(err_cnt == 0, {tag, " R8 no error"}, err_cnt, 0);
        end else begin
            chk(done_cnt == 0 && busy_cnt == 0, {tag, " R8 no done or busy"}, done_cnt + busy_cnt, 0);
            chk(err_cnt == 1 && err_cyc == 1, {tag, " R8 error pulse"}, err_cyc, 1);
        end
        chk(others == 0, {tag, " R3 other lines quiet"}, others, 0);
        chk(quiet_bad == 0, {tag, " R10 data quiet"}, quiet_bad, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(fuse_clk_en_o == '0 && !busy_o && !done_o && !err_o && !load_o && !unload_o,
            "R1 reset state", {fuse_clk_en_o, busy_o, done_o, err_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(fuse_clk_en_o == '0 && !busy_o && !done_o && !err_o,
            "R1 idle after reset", {fuse_clk_en_o, busy_o, done_o, err_o}, 0);
        for (int id = 0; id < NM; id++) begin
            for (int m = 0; m < 2; m++) begin
                for (int pat = 0; pat < 3; pat++) begin
                    logic [31:0] nc = (pat == 0) ? 32'hFFFF_FFFF :
                                      (pat == 1) ? 32'hAAAA_5555 :
                                      32'(32'h9E37_79B9 * (id * 7 + m * 3 + 1));
                    logic [31:0] pr = 32'(32'h6A09_E667 * (id + 5 * pat + 1)) ^ 32'h0F0F_1234;
                    run_burst(id, m == 0, m == 1, pr, nc, 1'b0, "sweep");
                end
            end
        end
        for (int id = NM; id < 8; id++) run_burst(id, 1'b1, 1'b0, '0, '0, 1'b0, "R8 bad id");
        run_burst(8 - 1, 1'b0, 1'b1, '0, '0, 1'b0, "R8 bad id merge");
        run_burst(0, 1'b1, 1'b0, 32'h0, 32'h0000_00C3, 1'b1, "R7 retrigger");
        run_burst(2, 1'b0, 1'b1, 32'h000F_0F0F, 32'h0000_3000, 1'b1, "R7 retrigger merge");
        run_burst(1, 1'b1, 1'b1, 32'h0000_0A0A, 32'h0000_0505, 1'b0, "R9 both triggers");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule